// File: doc/BRIEF.md
# Dual-Mode Serial Receive Buffer

This block holds received characters for a 16550-class serial port until the host reads them. It has two modes. In the legacy mode it keeps a single character. In the queued mode it keeps up to sixteen characters in arrival order. A level input selects the mode. The block tracks that input and clears the buffer whenever the selected mode differs from the one in force. The same thing happens when a receiver-clear command arrives while the queued mode is in force.

Characters come in on a push strobe, from the deserialiser or from a loopback path. The host takes them out with a pop strobe, and the head character appears on the read-data output in the same cycle. The block reports the number of held characters and whether it holds any or is at capacity. It also flags a push that found no room, which the register layer above uses to set its overrun status. Register decode, bit-level reception and trigger-level interrupts are handled elsewhere.

Top module: `uart_rx_buffer`

## Requirements
- R1: A synchronous active-low reset leaves the buffer empty and in legacy mode. After reset, `level_o` is 0, `has_data_o` is 0, `at_capacity_o` is 0 and `rd_data_o` reads 0xFF.
- R2: In legacy mode (`queue_mode_i` = 0) the capacity is one character. After one accepted push, `at_capacity_o` is 1 and `level_o` is 1.
- R3: In queued mode (`queue_mode_i` = 1) the capacity is `DEPTH` characters (16 by default). Characters are popped in the order they were pushed.
- R4: When `queue_mode_i` differs from the mode in force at a clock edge, the buffer is emptied and takes the capacity of the new mode. Any push or pop in that cycle is discarded.
- R5: In queued mode, `rx_clear_i` = 1 empties the buffer at the next edge and leaves capacity at `DEPTH`. It takes priority over a push or pop in the same cycle.
- R6: In legacy mode, `rx_clear_i` has no effect: the held character, the level and the status outputs are unchanged.
- R7: A push while the buffer is at capacity is not stored, and `push_rej_o` is 1 in that cycle. This holds even when a pop is made in the same cycle, and the pop is still honoured. `push_rej_o` is 0 in a cycle that empties the buffer.
- R8: While the buffer is empty, `rd_data_o` reads 0xFF. A pop with no push leaves the level at 0.
- R9: A push and a pop in the same cycle, on a buffer that is neither empty nor full, are both honoured: the level is unchanged and the order is kept.
- R10: A push and a pop in the same cycle on an empty buffer store the pushed character, and the pop returns 0xFF.
- R11: The read and write positions wrap around the current capacity. Arrival order is kept across any number of wraps.
- R12: `has_data_o` is 1 exactly when `level_o` is nonzero, and `at_capacity_o` is 1 exactly when `level_o` equals the current capacity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| queue_mode_i | input | 1 | 1 selects queued mode, 0 selects legacy single-character mode |
| rx_clear_i | input | 1 | Receiver-clear command, honoured only in queued mode |
| push_i | input | 1 | Store `push_data_i` |
| push_data_i | input | DATA_W | Character to store |
| pop_i | input | 1 | Remove the head character |
| rd_data_o | output | DATA_W | Head character, or 0xFF when empty |
| level_o | output | $clog2(DEPTH+1) | Number of characters held |
| has_data_o | output | 1 | Buffer holds at least one character |
| at_capacity_o | output | 1 | Buffer holds as many characters as the current mode allows |
| push_rej_o | output | 1 | Push in this cycle was refused for lack of room |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and DEPTH = 16, so that both real capacities, 1 and 16, are exercised. Directed passes drive each mode to capacity and beyond. They also cover the same-cycle collisions: a push with a pop when empty, partly full and full, and a clear or mode switch against a push. A long pseudo-random sweep biased toward pushing follows. It toggles the mode and issues clears, so the positions wrap many times at both capacities. A queue model in the bench predicts every output in every cycle.

// File: rtl/uart_rx_buffer_pkg.sv
// Shared definitions for the serial receive buffer.
// Assumes: characters are 8 bits wide unless a user overrides DATA_W.
package uart_rx_buffer_pkg;

    // Operating mode of the buffer
    typedef enum logic {
        MODE_LEGACY = 1'b0,
        MODE_QUEUED = 1'b1
    } rxb_mode_e;

    // Value returned on a read of an empty buffer
    localparam logic [7:0] RXB_IDLE_BYTE = 8'hFF;

endpackage

// File: rtl/uart_rx_buffer_store.sv
// Character storage: DEPTH registers with one write port and one read port.
// Assumes: the caller only writes when room exists; the read port is
// combinational so the head character is visible in the cycle of a pop.
module uart_rx_buffer_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Load one storage slot when it is the write target
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == PTR_W'(g))) begin
                slot_q[g] <= wr_data_i;
            end
        end
    end

    // Select the slot at the read position
    always_comb begin
        rd_data_o = slot_q[rd_idx_i];
    end

    // A write target must name a slot that exists
    always_ff @(posedge clk) begin
        if (rst_n && wr_en_i) begin
            assert_wr_in_range_R11: assert (int'(wr_idx_i) < DEPTH)
                else $error("write index out of range");
        end
    end

endmodule

// File: rtl/uart_rx_buffer_ctrl.sv
// Position, level and mode tracking for the receive buffer.
// Assumes DEPTH >= 2. Capacity is 1 in legacy mode and DEPTH in queued mode.
// A mode change or a queued-mode clear empties the buffer and wins over
// any push or pop in the same cycle.
module uart_rx_buffer_ctrl
    import uart_rx_buffer_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             queue_mode_i,
    input  logic             rx_clear_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [CNT_W-1:0] level_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             push_rej_o
);

    localparam logic [CNT_W-1:0] CAP_QUEUED = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CAP_LEGACY = CNT_W'(1);

    rxb_mode_e        mode_q;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap;
    logic             mode_chg, wipe, do_push, do_pop;

    // Advance a position, wrapping at the current capacity
    function automatic logic [PTR_W-1:0] step_pos(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] c);
        if ((CNT_W'(p) + CNT_W'(1)) >= c) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    // Derive capacity, clear conditions and accepted operations
    always_comb begin
        cap        = (mode_q == MODE_QUEUED) ? CAP_QUEUED : CAP_LEGACY;
        mode_chg   = (rxb_mode_e'(queue_mode_i) != mode_q);
        wipe       = mode_chg || (rx_clear_i && (mode_q == MODE_QUEUED));
        empty_o    = (cnt_q == '0);
        full_o     = (cnt_q == cap);
        do_push    = push_i && !full_o && !wipe;
        do_pop     = pop_i && !empty_o && !wipe;
        push_rej_o = push_i && full_o && !wipe;
    end

    // Update mode, positions and level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_LEGACY;
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
        end else if (wipe) begin
            mode_q <= rxb_mode_e'(queue_mode_i);
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) begin
                wr_q <= step_pos(wr_q, cap);
            end
            if (do_pop) begin
                rd_q <= step_pos(rd_q, cap);
            end
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Drive the outputs toward storage and the top level
    always_comb begin
        wr_en_o  = do_push;
        wr_idx_o = wr_q;
        rd_idx_o = rd_q;
        level_o  = cnt_q;
    end

    // Level never exceeds the queued capacity
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP_QUEUED);

    // Legacy mode never holds more than one character
    assert_legacy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_LEGACY) |-> (cnt_q <= CAP_LEGACY));

    // A mode switch leaves the buffer empty in the requested mode
    assert_mode_switch_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rxb_mode_e'(queue_mode_i) != mode_q) |=>
            (cnt_q == '0) && (mode_q == $past(rxb_mode_e'(queue_mode_i))));

    // A queued-mode clear empties the buffer
    assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clear_i && queue_mode_i && (mode_q == MODE_QUEUED)) |=>
            (cnt_q == '0) && (mode_q == MODE_QUEUED));

    // A clear in legacy mode with no other activity changes nothing
    assert_legacy_clear_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clear_i && !queue_mode_i && (mode_q == MODE_LEGACY) && !push_i && !pop_i)
            |=> $stable(cnt_q) && $stable(rd_q));

    // A refused push with no pop leaves the level unchanged
    assert_reject_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_rej_o && !pop_i) |=> $stable(cnt_q));

    // A lone pop from an empty buffer leaves it empty
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && (cnt_q == '0) && !push_i) |=> (cnt_q == '0));

    // Push with pop on a partly filled buffer keeps the level
    assert_pass_through_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !wipe && (cnt_q != '0) && (cnt_q != cap))
            |=> $stable(cnt_q));

endmodule

// File: rtl/uart_rx_buffer.sv
// Receive character buffer for a 16550-class serial port.
// Holds one character in legacy mode or DEPTH characters in queued mode.
// The head character is shown combinationally; an empty buffer reads as
// the idle byte. Assumes DEPTH >= 2 and DATA_W >= 8.
module uart_rx_buffer
    import uart_rx_buffer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              queue_mode_i,
    input  logic              rx_clear_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CNT_W-1:0]  level_o,
    output logic              has_data_o,
    output logic              at_capacity_o,
    output logic              push_rej_o
);

    logic             wr_en;
    logic [PTR_W-1:0] wr_idx, rd_idx;
    logic [DATA_W-1:0] head;
    logic             empty, full;

    uart_rx_buffer_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .queue_mode_i (queue_mode_i),
        .rx_clear_i   (rx_clear_i),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .rd_idx_o     (rd_idx),
        .level_o      (level_o),
        .empty_o      (empty),
        .full_o       (full),
        .push_rej_o   (push_rej_o)
    );

    uart_rx_buffer_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_data_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (head)
    );

    // Present the head character or the idle byte, plus status flags
    always_comb begin
        rd_data_o     = empty ? DATA_W'(RXB_IDLE_BYTE) : head;
        has_data_o    = !empty;
        at_capacity_o = full;
    end

    // An empty buffer always reads as the idle byte
    assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (level_o == '0) |-> (rd_data_o == DATA_W'(RXB_IDLE_BYTE)));

    // Flags agree with the level
    assert_flags_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        has_data_o == (level_o != '0));

endmodule

// File: tb/tb_uart_rx_buffer.sv
// Self-checking bench: a queue model predicts every output in every cycle.
module tb_uart_rx_buffer;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DEPTH      = 16;
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              queue_mode_i;
    logic              rx_clear_i;
    logic              push_i;
    logic [DATA_W-1:0] push_data_i;
    logic              pop_i;
    logic [DATA_W-1:0] rd_data_o;
    logic [CNT_W-1:0]  level_o;
    logic              has_data_o;
    logic              at_capacity_o;
    logic              push_rej_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    int mq[$];
    bit mmode;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_rx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .queue_mode_i  (queue_mode_i),
        .rx_clear_i    (rx_clear_i),
        .push_i        (push_i),
        .push_data_i   (push_data_i),
        .pop_i         (pop_i),
        .rd_data_o     (rd_data_o),
        .level_o       (level_o),
        .has_data_o    (has_data_o),
        .at_capacity_o (at_capacity_o),
        .push_rej_o    (push_rej_o)
    );

    function automatic int mcap();
        return mmode ? DEPTH : 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Compare registered state against the model
    task automatic chk_state(input string tag);
        chk({tag, " level"}, int'(level_o), mq.size());
        chk({tag, " R12 has_data"}, int'(has_data_o), int'(mq.size() != 0));
        chk({tag, " R12 at_capacity"}, int'(at_capacity_o), int'(mq.size() == mcap()));
        chk({tag, " R8 read data"}, int'(rd_data_o), (mq.size() != 0) ? mq[0] : 8'hFF);
    endtask

    // One cycle: drive at the falling edge, check, clock, update model, check
    task automatic step(input bit ps, input int d, input bit pp, input bit cl,
                        input bit md, input string tag);
        bit wipe, full_pre;
        int head;
        push_i       = ps;
        push_data_i  = DATA_W'(d);
        pop_i        = pp;
        rx_clear_i   = cl;
        queue_mode_i = md;
        #1;
        wipe     = (md != mmode) || (cl && mmode);
        full_pre = (mq.size() == mcap());
        head     = (mq.size() != 0) ? mq[0] : 8'hFF;
        chk({tag, " R7 reject flag"}, int'(push_rej_o), int'(ps && full_pre && !wipe));
        chk({tag, " R8 pop data"}, int'(rd_data_o), head);
        @(posedge clk);
        if (wipe) begin
            mq.delete();
            mmode = md;
        end else begin
            if (pp && mq.size() != 0) void'(mq.pop_front());
            if (ps && !full_pre) mq.push_back(d & 8'hFF);
        end
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; rx_clear_i = 1'b0;
        chk_state(tag);
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    bit done = 0;

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; queue_mode_i = 1'b0; rx_clear_i = 1'b0;
        push_i = 1'b0; pop_i = 1'b0; push_data_i = '0;
        mmode = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 level", int'(level_o), 0);
        chk("R1 has_data", int'(has_data_o), 0);
        chk("R1 at_capacity", int'(at_capacity_o), 0);
        chk("R1 read data", int'(rd_data_o), 8'hFF);
        @(negedge clk);

        // R2: legacy capacity one
        step(1, 8'h41, 0, 0, 0, "R2 first push");
        chk("R2 full after one", int'(at_capacity_o), 1);
        step(1, 8'h42, 0, 0, 0, "R7 legacy overflow");
        // R6: clear ignored in legacy mode
        step(0, 0, 0, 1, 0, "R6 legacy clear");
        chk("R6 held char", int'(rd_data_o), 8'h41);
        step(0, 0, 1, 0, 0, "R2 pop");
        // R8: pop from empty
        step(0, 0, 1, 0, 0, "R8 empty pop");
        // R10: push and pop on empty
        step(1, 8'h55, 1, 0, 0, "R10 legacy collide");
        chk("R10 stored", int'(level_o), 1);
        // R7: full legacy with push and pop: pop honoured, push refused
        step(1, 8'h66, 1, 0, 0, "R7 full collide");
        chk("R7 level after", int'(level_o), 0);

        // R4: switch to queued mode while pushing
        step(1, 8'h11, 0, 0, 1, "R4 switch with push");
        chk("R4 emptied", int'(level_o), 0);
        // R3: fill to DEPTH, then overflow
        for (int i = 0; i < DEPTH; i++) step(1, 8'h80 + i, 0, 0, 1, "R3 fill");
        chk("R3 capacity", int'(level_o), DEPTH);
        step(1, 8'hEE, 0, 0, 1, "R7 queued overflow");
        step(1, 8'hEF, 1, 0, 1, "R7 queued full collide");
        // R9: push and pop on partly filled
        for (int i = 0; i < 5; i++) step(1, 8'h20 + i, 1, 0, 1, "R9 pass through");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0, 1, "R3 drain order");
        step(1, 8'h33, 1, 0, 1, "R10 queued collide");
        // R5: clear with push in queued mode
        step(1, 8'h34, 0, 0, 1, "R5 prefill");
        step(1, 8'h35, 1, 1, 1, "R5 clear wins");
        chk("R5 emptied", int'(level_o), 0);
        for (int i = 0; i < DEPTH; i++) step(1, i, 0, 0, 1, "R5 capacity kept");
        chk("R5 capacity after clear", int'(level_o), DEPTH);
        // R4: back to legacy with pop
        step(0, 0, 1, 0, 0, "R4 switch to legacy");
        step(1, 8'h77, 0, 0, 0, "R4 legacy cap");
        step(1, 8'h78, 0, 0, 0, "R4 legacy overflow");

        // R11: pseudo-random sweep across wraps and mode changes
        begin
            bit md = 1;
            for (int i = 0; i < 6000; i++) begin
                bit ps, pp, cl;
                lfsr = lfsr_next(lfsr);
                ps = (lfsr[2:0] < 3'd5);
                pp = (lfsr[5:3] < 3'd4);
                cl = (lfsr[15:9] == 7'd3);
                if (lfsr[15:8] == 8'd7) md = !md;
                step(ps, int'(lfsr[7:0] ^ lfsr[15:8]), pp, cl, md, "R11 sweep");
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule